// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block turns a single request into the command and address cycles of a raw NAND flash bus. A request holds a command byte, a column with its own present flag, a page address with its own present flag, and the block's configuration selects small-page or large-page devices, 8-bit or 16-bit data width, the main page size, the chip size in MiB and whether a ready/busy line is wired. The block drives the command latch enable, the address latch enable, an active-low write strobe and the output byte. Where the command calls for it, the block then waits for the device to finish its busy phase.

The block rewrites some requests on its own.

- **Small-page, sequential data input:** it issues a pointer command first, chosen from the column.
- **Large-page, out-of-band read:** it turns the request into a main-area read at a shifted column.
- **Large-page, main read:** it adds a read-start confirm cycle.
- **Address cycles:** their number depends on the page type and on the chip size.

A reset on a device without a ready/busy line ends by polling the status register with read strobes. A one-cycle done pulse marks the end of every sequence.

Top module: `nand_cmd_seq`

## Requirements
- R1: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready then stays low until the sequence ends. done is high for exactly one cycle, after which req_ready is high again.
- R2: Command bytes go out with nand_cle high and nand_ale low. Address bytes go out with nand_ale high and nand_cle low. nand_we_n is low only while exactly one of the two latch enables is high. nand_dq_out and the latch enables do not change while nand_we_n is low. A request with neither a column nor a page produces no address cycle.
- R3: In small-page mode a command 0x80 is preceded by a pointer command that depends on the column. If the column is greater than or equal to the page size, the pointer is 0x50 and the page size is subtracted from the column. If the column is below 256, the pointer is 0x00. Otherwise the pointer is 0x01 and 256 is subtracted from the column.
- R4: In small-page mode the column goes out as one byte. The page goes out low byte first as two bytes, and when the chip size is above 32 MiB a third byte follows holding page bits 19:16 with its upper nibble zero.
- R5: In large-page mode the column goes out as two bytes, low byte first. The page goes out as two bytes, and when the chip size is above 128 MiB a third byte follows holding page bits 23:16.
- R6: With cfg_bus16 high, the column (after any adjustment from R3 or R7) is shifted right by one before it is sent.
- R7: In large-page mode a command 0x50 is sent as 0x00 with the page size added to the column. Every large-page 0x00 is followed, after its address cycles, by a command cycle 0x30.
- R8: Commands 0x10, 0x60, 0xD0, 0x80 and 0x70, and 0x15 in large-page mode, finish right after their last byte without looking at nand_rb. done comes T_PULSE+T_HOLD cycles after the last strobe falls.
- R9: With cfg_has_rb high, any other command waits T_WB cycles and then for nand_rb to be high before done. This includes a large-page 0x00 and 0xFF.
- R10: With cfg_has_rb low, a read-type command waits T_CHIP cycles whatever nand_rb does. done comes T_PULSE+T_HOLD+T_CHIP cycles after the last strobe falls.
- R11: With cfg_has_rb low, command 0xFF is handled as follows.
  - After its byte and T_CHIP cycles, the block sends a 0x70 command cycle.
  - It then repeats read strobes on nand_re_n, each low T_PULSE cycles and high T_HOLD cycles, until the sampled nand_dq_in has bit 6 set.
  - During the read strobes nand_we_n, nand_cle and nand_ale are inactive.
- R12: Each write strobe is preceded by T_SETUP cycles and followed by T_HOLD cycles with the byte and latch enable already valid. Each write strobe is low for exactly T_PULSE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_large | input | 1 | 1 = large-page device, 0 = small-page |
| cfg_bus16 | input | 1 | 16-bit data bus, halves the column |
| cfg_has_rb | input | 1 | Ready/busy line is wired |
| cfg_page_bytes | input | 16 | Main page size in bytes |
| cfg_chip_mib | input | 16 | Chip size in MiB |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, accepts a request |
| req_cmd | input | 8 | Command byte |
| req_col | input | 16 | Column address |
| req_col_en | input | 1 | Column present |
| req_page | input | 24 | Page address |
| req_page_en | input | 1 | Page present |
| done | output | 1 | One-cycle end-of-sequence pulse |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven to the device |
| nand_dq_in | input | 8 | Byte read from the device |
| nand_rb | input | 1 | Ready/busy, high = ready |

## Verification
Sequential data input on a small-page device is sent with columns below 256, between 256 and the page size, and at or beyond the page size. These three cases tell the three pointer choices apart and show each column adjustment. The chip size is set just at and above the two thresholds, so the runs separate two-byte from three-byte page addresses and show the 4-bit mask on small-page devices. Large-page out-of-band reads and 16-bit reads, status with no address, and erase and cache program with ready/busy held low all have their byte streams checked against a queue. Read-type and reset commands are run with and without a ready/busy line to tell a busy wait, a fixed delay and status polling apart by the cycle in which done arrives.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 3,
  parameter int T_HOLD  = 2,
  parameter int T_WB    = 20,
  parameter int T_CHIP  = 5000,
  parameter int RDY_BIT = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_large,
  input  logic        cfg_bus16,
  input  logic        cfg_has_rb,
  input  logic [15:0] cfg_page_bytes,
  input  logic [15:0] cfg_chip_mib,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_cmd,
  input  logic [15:0] req_col,
  input  logic        req_col_en,
  input  logic [23:0] req_page,
  input  logic        req_page_en,
  output logic        done,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_out,
  input  logic [7:0]  nand_dq_in,
  input  logic        nand_rb
);
  localparam int TMAX  = (T_CHIP > T_WB) ? T_CHIP : T_WB;
  localparam int CNT_W = $clog2(TMAX + 1) + 1;
  localparam logic [CNT_W-1:0] C_SU = CNT_W'(T_SETUP - 1);
  localparam logic [CNT_W-1:0] C_PU = CNT_W'(T_PULSE - 1);
  localparam logic [CNT_W-1:0] C_HO = CNT_W'(T_HOLD - 1);
  localparam logic [CNT_W-1:0] C_WB = CNT_W'(T_WB - 1);
  localparam logic [CNT_W-1:0] C_CD = CNT_W'(T_CHIP - 1);
  localparam logic [7:0] RDY_MASK = 8'(1 << RDY_BIT);

  typedef enum logic [2:0] {S_IDLE, S_EMIT, S_WB, S_RBW, S_DLY, S_RD, S_RH, S_FIN} st_t;
  typedef enum logic [2:0] {W_NONE, W_RB, W_DLY, W_RST, W_POLL} wm_t;

  st_t              st;
  wm_t              wm, nw;
  logic [8:0]       lst [8];
  logic [8:0]       nb  [8];
  logic [3:0]       len, nn;
  logic [2:0]       idx;
  logic [1:0]       ph;
  logic [CNT_W-1:0] cnt;
  logic             rdy_hit;
  logic [7:0]       opc, pre;
  logic [15:0]      colv;
  logic             pre_en;

  always_comb begin
    for (int i = 0; i < 8; i++) nb[i] = '0;
    nn     = '0;
    opc    = req_cmd;
    pre    = 8'h00;
    pre_en = 1'b0;
    colv   = req_col_en ? req_col : 16'h0;
    if (!cfg_large && req_cmd == 8'h80) begin
      pre_en = 1'b1;
      if (colv >= cfg_page_bytes) begin
        pre  = 8'h50;
        colv = colv - cfg_page_bytes;
      end else if (colv >= 16'd256) begin
        pre  = 8'h01;
        colv = colv - 16'd256;
      end
    end
    if (cfg_large && req_cmd == 8'h50) begin
      opc  = 8'h00;
      colv = colv + cfg_page_bytes;
    end
    if (cfg_bus16) colv = colv >> 1;
    if (pre_en) begin nb[nn[2:0]] = {1'b1, pre}; nn = nn + 4'd1; end
    nb[nn[2:0]] = {1'b1, opc}; nn = nn + 4'd1;
    if (req_col_en) begin
      nb[nn[2:0]] = {1'b0, colv[7:0]}; nn = nn + 4'd1;
      if (cfg_large) begin nb[nn[2:0]] = {1'b0, colv[15:8]}; nn = nn + 4'd1; end
    end
    if (req_page_en) begin
      nb[nn[2:0]] = {1'b0, req_page[7:0]};  nn = nn + 4'd1;
      nb[nn[2:0]] = {1'b0, req_page[15:8]}; nn = nn + 4'd1;
      if (cfg_large && cfg_chip_mib > 16'd128) begin
        nb[nn[2:0]] = {1'b0, req_page[23:16]}; nn = nn + 4'd1;
      end else if (!cfg_large && cfg_chip_mib > 16'd32) begin
        nb[nn[2:0]] = {1'b0, 4'h0, req_page[19:16]}; nn = nn + 4'd1;
      end
    end
    if (cfg_large && opc == 8'h00) begin nb[nn[2:0]] = {1'b1, 8'h30}; nn = nn + 4'd1; end
    case (opc)
      8'h10, 8'h60, 8'hD0, 8'h80, 8'h70: nw = W_NONE;
      8'h15:   nw = cfg_large ? W_NONE : (cfg_has_rb ? W_RB : W_DLY);
      8'hFF:   nw = cfg_has_rb ? W_RB : W_RST;
      default: nw = cfg_has_rb ? W_RB : W_DLY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; wm <= W_NONE; len <= '0; idx <= '0; ph <= '0; cnt <= '0; rdy_hit <= 1'b0;
      for (int i = 0; i < 8; i++) lst[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          for (int i = 0; i < 8; i++) lst[i] <= nb[i];
          len <= nn; wm <= nw; idx <= '0; ph <= 2'd0; cnt <= C_SU; st <= S_EMIT;
        end
        S_EMIT: if (cnt != '0) cnt <= cnt - 1'b1;
          else if (ph == 2'd0) begin ph <= 2'd1; cnt <= C_PU; end
          else if (ph == 2'd1) begin ph <= 2'd2; cnt <= C_HO; end
          else if ({1'b0, idx} != len - 4'd1) begin
            idx <= idx + 3'd1; ph <= 2'd0; cnt <= C_SU;
          end else case (wm)
            W_NONE:       st <= S_FIN;
            W_RB:         begin st <= S_WB;  cnt <= C_WB; end
            W_DLY, W_RST: begin st <= S_DLY; cnt <= C_CD; end
            default:      begin st <= S_RD;  cnt <= C_PU; end
          endcase
        S_WB:  if (cnt != '0) cnt <= cnt - 1'b1; else st <= S_RBW;
        S_RBW: if (nand_rb) st <= S_FIN;
        S_DLY: if (cnt != '0) cnt <= cnt - 1'b1;
          else if (wm == W_RST) begin
            lst[0] <= {1'b1, 8'h70}; len <= 4'd1; idx <= '0; ph <= 2'd0;
            cnt <= C_SU; wm <= W_POLL; st <= S_EMIT;
          end else st <= S_FIN;
        S_RD: if (cnt != '0) cnt <= cnt - 1'b1;
          else begin rdy_hit <= |(nand_dq_in & RDY_MASK); cnt <= C_HO; st <= S_RH; end
        S_RH: if (cnt != '0) cnt <= cnt - 1'b1;
          else if (rdy_hit) st <= S_FIN;
          else begin cnt <= C_PU; st <= S_RD; end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire [8:0] cur = lst[idx];
  assign req_ready   = (st == S_IDLE);
  assign done        = (st == S_FIN);
  assign nand_cle    = (st == S_EMIT) &&  cur[8];
  assign nand_ale    = (st == S_EMIT) && !cur[8];
  assign nand_we_n   = !((st == S_EMIT) && ph == 2'd1);
  assign nand_re_n   = (st != S_RD);
  assign nand_dq_out = (st == S_EMIT) ? cur[7:0] : 8'h00;

  assert_strobe_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> (nand_cle ^ nand_ale));
  assert_bus_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && !$past(nand_we_n)) |-> ($stable(nand_dq_out) && $stable(nand_cle) && $stable(nand_ale)));
  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  assert_accept_only_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));
  assert_read_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> (nand_we_n && !nand_cle && !nand_ale));
  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_re_n && !nand_we_n));
endmodule

// File: tb/nand_cmd_seq_test.sv
`timescale 1ns/1ps
module nand_cmd_seq_test;
  localparam int TP = 2, TH = 1, TS = 1, TWB = 4, TCD = 40;

  logic clk = 0, rst_n = 0;
  logic cfg_large = 0, cfg_bus16 = 0, cfg_has_rb = 1;
  logic [15:0] cfg_page_bytes = 16'd512, cfg_chip_mib = 16'd32;
  logic req_valid = 0, req_ready, req_col_en = 0, req_page_en = 0;
  logic [7:0] req_cmd = 0;
  logic [15:0] req_col = 0;
  logic [23:0] req_page = 0;
  logic done, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_rb = 1;
  logic [7:0] nand_dq_out, nand_dq_in;

  int checks = 0, errors = 0, cyc = 0, reads = 0, done_cnt = 0, low_len = 0;
  int last_fall = 0, done_cyc = 0;
  logic prev_we = 1, prev_re = 1;
  logic [8:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;
  assign nand_dq_in = (reads >= 3) ? 8'h40 : 8'h00;

  nand_cmd_seq #(.T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .T_WB(TWB), .T_CHIP(TCD)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_large(cfg_large), .cfg_bus16(cfg_bus16), .cfg_has_rb(cfg_has_rb),
    .cfg_page_bytes(cfg_page_bytes), .cfg_chip_mib(cfg_chip_mib), .req_valid(req_valid),
    .req_ready(req_ready), .req_cmd(req_cmd), .req_col(req_col), .req_col_en(req_col_en),
    .req_page(req_page), .req_page_en(req_page_en), .done(done), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb));

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, expv); end
  endtask

  task automatic push(input bit cle, input [7:0] b, input string tag);
    exp_q.push_back({cle, b}); tag_q.push_back(tag);
  endtask

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (!nand_we_n && prev_we) begin
      last_fall = cyc;
      if (exp_q.size() == 0) chk(0, "R2 unexpected byte", {nand_cle, nand_dq_out}, 0);
      else begin
        logic [8:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk({nand_cle, nand_dq_out} == e && nand_ale == !nand_cle, t, {nand_cle, nand_dq_out}, e);
      end
    end
    if (!nand_we_n) low_len++;
    if (nand_we_n && !prev_we) begin chk(low_len == TP, "R12 strobe width", low_len, TP); low_len = 0; end
    if (!nand_re_n && prev_re) reads++;
    if (done) begin done_cnt++; done_cyc = cyc; end
    prev_we = nand_we_n; prev_re = nand_re_n;
  end

  task automatic issue(input [7:0] c, input [15:0] col, input bit ce, input [23:0] pg, input bit pe);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_cmd = c; req_col = col; req_col_en = ce; req_page = pg; req_page_en = pe; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R1 busy after accept", req_ready, 0);
  endtask

  task automatic await_done(input int base, input string tag);
    int n = 0;
    while (done_cnt == base && n < 3000) begin @(negedge clk); n++; end
    chk(done_cnt == base + 1, tag, done_cnt - base, 1);
    chk(exp_q.size() == 0, {tag, " bytes left"}, exp_q.size(), 0);
    @(negedge clk);
    chk(req_ready && !done, "R1 ready after done", {req_ready, done}, 2);
  endtask

  initial begin
    #(5.0 * 190000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !nand_cle && !nand_ale && nand_we_n && nand_re_n,
        "R1 reset state", {req_ready, done, nand_cle, nand_ale, nand_we_n, nand_re_n}, 6'b100011);
    rst_n = 1;

    nand_rb = 0;
    push(1, 8'h00, "R3 pointer low"); push(1, 8'h80, "R2 cmd");
    push(0, 8'h10, "R4 col"); push(0, 8'h45, "R4 p0"); push(0, 8'h23, "R4 p1");
    b = done_cnt; issue(8'h80, 16'h0010, 1, 24'h012345, 1); await_done(b, "R8 immediate seqin");
    chk(done_cyc - last_fall == TP + TH, "R8 no busy wait", done_cyc - last_fall, TP + TH);

    cfg_chip_mib = 16'd64;
    push(1, 8'h01, "R3 pointer mid"); push(1, 8'h80, "R2 cmd");
    push(0, 8'h23, "R3 col-256"); push(0, 8'h45, "R4 p0"); push(0, 8'h23, "R4 p1"); push(0, 8'h01, "R4 p2 masked");
    b = done_cnt; issue(8'h80, 16'h0123, 1, 24'hA12345, 1); await_done(b, "R3 mid");

    push(1, 8'h50, "R3 pointer oob"); push(1, 8'h80, "R2 cmd");
    push(0, 8'h05, "R3 col-page"); push(0, 8'h02, "R4 p0"); push(0, 8'h00, "R4 p1"); push(0, 8'h00, "R4 p2");
    b = done_cnt; issue(8'h80, 16'h0205, 1, 24'h000002, 1); await_done(b, "R3 oob");

    push(1, 8'h60, "R8 erase"); push(0, 8'h77, "R4 p0"); push(0, 8'h00, "R4 p1"); push(0, 8'h00, "R4 p2");
    b = done_cnt; issue(8'h60, 16'h0, 0, 24'h000077, 1); await_done(b, "R8 erase");

    push(1, 8'h70, "R2 status no addr");
    b = done_cnt; issue(8'h70, 16'h0, 0, 24'h0, 0); await_done(b, "R8 status");

    cfg_chip_mib = 16'd32;
    push(1, 8'h00, "R2 read"); push(0, 8'h40, "R4 col"); push(0, 8'h77, "R4 p0"); push(0, 8'h00, "R4 p1");
    b = done_cnt; issue(8'h00, 16'h0040, 1, 24'h000077, 1);
    repeat (60) @(negedge clk);
    chk(done_cnt == b, "R9 waits for ready", done_cnt - b, 0);
    nand_rb = 1; await_done(b, "R9 ready ends wait");

    cfg_large = 1; cfg_page_bytes = 16'd2048; cfg_chip_mib = 16'd256; nand_rb = 0;
    push(1, 8'h00, "R7 oob as read0"); push(0, 8'h04, "R5 c0"); push(0, 8'h08, "R7 col+page");
    push(0, 8'h01, "R5 p0"); push(0, 8'h02, "R5 p1"); push(0, 8'h03, "R5 p2"); push(1, 8'h30, "R7 readstart");
    b = done_cnt; issue(8'h50, 16'h0004, 1, 24'h030201, 1);
    repeat (60) @(negedge clk);
    chk(done_cnt == b, "R9 large read waits", done_cnt - b, 0);
    nand_rb = 1; await_done(b, "R9 large read");

    cfg_bus16 = 1; cfg_chip_mib = 16'd128;
    push(1, 8'h00, "R2 read"); push(0, 8'h80, "R6 col halved"); push(0, 8'h00, "R6 col hi");
    push(0, 8'h10, "R5 p0"); push(0, 8'h00, "R5 p1"); push(1, 8'h30, "R7 readstart");
    b = done_cnt; issue(8'h00, 16'h0100, 1, 24'h000010, 1); await_done(b, "R6 bus16 read");
    cfg_bus16 = 0;

    nand_rb = 0;
    push(1, 8'h15, "R8 cache prog"); push(0, 8'h09, "R5 p0"); push(0, 8'h00, "R5 p1");
    b = done_cnt; issue(8'h15, 16'h0, 0, 24'h000009, 1); await_done(b, "R8 cache prog");
    chk(done_cyc - last_fall == TP + TH, "R8 cache no wait", done_cyc - last_fall, TP + TH);

    cfg_large = 0; cfg_page_bytes = 16'd512; cfg_chip_mib = 16'd32; cfg_has_rb = 0; nand_rb = 1;
    push(1, 8'h00, "R10 read"); push(0, 8'h11, "R4 col");
    b = done_cnt; issue(8'h00, 16'h0011, 1, 24'h0, 0); await_done(b, "R10 fixed delay");
    chk(done_cyc - last_fall == TP + TH + TCD, "R10 delay length", done_cyc - last_fall, TP + TH + TCD);

    nand_rb = 0; reads = 0;
    push(1, 8'hFF, "R11 reset"); push(1, 8'h70, "R11 status poll cmd");
    b = done_cnt; issue(8'hFF, 16'h0, 0, 24'h0, 0); await_done(b, "R11 reset poll");
    chk(reads == 3, "R11 read strobes until ready bit", reads, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule